// File: doc/BRIEF.md
# VGA Raster Timing Generator with Access Windows

This block produces the raster timing for a 640x480 display driven from a 25.175 MHz master clock. A horizontal position counter advances on every clock. A vertical line counter advances once per line. Registered decode logic turns these two counts into active-low horizontal and vertical sync and three separate blanking flags. The first flag is the true display blank. The second is an access window for a microcontroller. The third is a flag that is set only during vertical retrace.

The access window follows the display blank but closes a fixed number of clocks before the next visible pixel. A microcontroller that starts a memory write while the window is open therefore always finishes before the display needs the video memory again. The vertical-only flag marks the retrace once per frame and can be wired to an interrupt input. A half-rate pixel enable gives 320 samples across each visible line. The current column and line are output so that a frame buffer can be addressed.

Top module: `vga_raster_timer`

## Requirements
- R1: `hpos` counts 0 to H_TOTAL-1 (default 800) by one per clock and then wraps to 0. `vpos` advances by one only on the clock where `hpos` wraps, and wraps from V_TOTAL-1 (default 525) to 0. The default horizontal segments are 640 visible, 16 front porch, 96 sync and 48 back porch clocks. The default vertical segments are 480 visible, 10 front porch, 2 sync and 33 back porch lines.
- R2: `hsync_n` is 0 exactly when H_VIS+H_FP <= hpos < H_VIS+H_FP+H_SYNC (default columns 656 to 751), and is 1 otherwise.
- R3: `vsync_n` is 0 exactly when V_VIS+V_FP <= vpos < V_VIS+V_FP+V_SYNC (default lines 490 and 491), and is 1 otherwise.
- R4: `blank` is 1 exactly when hpos >= H_VIS or vpos >= V_VIS.
- R5: `acc_win` is 1 exactly when `blank` is 1, except during the last ACC_LEAD positions (default 4) before a visible pixel. Those positions are hpos >= H_TOTAL-ACC_LEAD on a line whose following line is visible, that is vpos < V_VIS-1 or vpos = V_TOTAL-1.
- R6: `frame_blank` is 1 exactly when vpos >= V_VIS. It therefore forms one unbroken pulse per frame.
- R7: `pix_en` is 1 exactly when the position is visible and `hpos` is even. This gives H_VIS/2 (default 320) enables per visible line and none in blanking.
- R8: All outputs come from registers and describe the same raster position, so every output changes only on a rising clock edge.
- R9: A clock edge with `rst` at 1 sets the position to column 0, line 0. At that position the outputs are `hsync_n`=1, `vsync_n`=1, `blank`=0, `acc_win`=0, `frame_blank`=0 and `pix_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | Display blank, set on any non-visible position |
| acc_win | output | 1 | Microcontroller access window, closes ACC_LEAD clocks before the next visible pixel |
| frame_blank | output | 1 | Set only during the vertical blanking lines |
| pix_en | output | 1 | Half-rate sample enable on even visible columns |
| hpos | output | $clog2(H_TOTAL) | Current column |
| vpos | output | $clog2(V_TOTAL) | Current line |

## Verification
The bench builds the block with a reduced raster and ACC_LEAD = 3. The horizontal segments are 16 visible, 2 front porch, 3 sync and 3 back porch clocks. The vertical segments are 6 visible, 1 front porch, 2 sync and 2 back porch lines. With this raster a whole frame takes 264 clocks, so several frame wraps, sync edges and the start and end of vertical retrace fall within a short run. The non-default lead shows that the window closes by parameter, both before visible lines and, on the final retrace line, before line 0 of the next frame. A reset applied in mid-line then shows the return to the origin.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic blank;
    logic acc_win;
    logic frame_blank;
    logic pix_en;
  } raster_flags_t;

endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int MOD = 800,
  localparam int W = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_comb begin
    if (rst)
      nxt = '0;
    else if (adv)
      nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
    else
      nxt = cnt;
  end

  always_ff @(posedge clk) begin
    cnt <= nxt;
  end

endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import vga_timing_pkg::*;
#(
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int ACC_LEAD = 4,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic [HW-1:0]  h,
  input  logic [VW-1:0]  v,
  output raster_flags_t  flags
);

  localparam logic [HW-1:0] H_VIS_T  = HW'(H_VIS);
  localparam logic [HW-1:0] HS_BEG   = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END   = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [HW-1:0] ACC_STOP = HW'(H_TOTAL - ACC_LEAD);
  localparam logic [VW-1:0] V_VIS_T  = VW'(V_VIS);
  localparam logic [VW-1:0] V_PRELST = VW'(V_VIS - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] VS_BEG   = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END   = VW'(V_VIS + V_FP + V_SYNC);

  logic h_off, v_off, next_line_shown, in_lead;

  always_comb begin
    h_off           = (h >= H_VIS_T);
    v_off           = (v >= V_VIS_T);
    next_line_shown = (v < V_PRELST) || (v == V_LAST);
    in_lead         = (h >= ACC_STOP) && next_line_shown;

    flags.hsync_n     = !((h >= HS_BEG) && (h < HS_END));
    flags.vsync_n     = !((v >= VS_BEG) && (v < VS_END));
    flags.blank       = h_off || v_off;
    flags.acc_win     = (h_off || v_off) && !in_lead;
    flags.frame_blank = v_off;
    flags.pix_en      = !(h_off || v_off) && !h[0];
  end

endmodule

// File: rtl/vga_raster_timer.sv
module vga_raster_timer
  import vga_timing_pkg::*;
#(
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int ACC_LEAD = 4,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blank,
  output logic          acc_win,
  output logic          frame_blank,
  output logic          pix_en,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

  logic [HW-1:0] h_cnt, h_nxt;
  logic [VW-1:0] v_cnt, v_nxt;
  logic          h_wrap;
  raster_flags_t dec_flags, out_flags;

  assign h_wrap = (h_cnt == H_LAST);

  scan_counter #(.MOD(H_TOTAL)) u_hcnt (
    .clk (clk),
    .rst (rst),
    .adv (1'b1),
    .cnt (h_cnt),
    .nxt (h_nxt)
  );

  scan_counter #(.MOD(V_TOTAL)) u_vcnt (
    .clk (clk),
    .rst (rst),
    .adv (h_wrap),
    .cnt (v_cnt),
    .nxt (v_nxt)
  );

  raster_decode #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ACC_LEAD(ACC_LEAD)
  ) u_dec (
    .h     (h_nxt),
    .v     (v_nxt),
    .flags (dec_flags)
  );

  // Flags are decoded from the upcoming count so they land in step with it.
  always_ff @(posedge clk) begin
    out_flags <= dec_flags;
  end

  assign hsync_n     = out_flags.hsync_n;
  assign vsync_n     = out_flags.vsync_n;
  assign blank       = out_flags.blank;
  assign acc_win     = out_flags.acc_win;
  assign frame_blank = out_flags.frame_blank;
  assign pix_en      = out_flags.pix_en;
  assign hpos        = h_cnt;
  assign vpos        = v_cnt;

endmodule

// File: rtl/vga_raster_timer_chk.sv
module vga_raster_timer_chk #(
  parameter int H_VIS    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int ACC_LEAD = 4,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          blank,
  input logic          acc_win,
  input logic          frame_blank,
  input logic          pix_en,
  input logic [HW-1:0] hpos,
  input logic [VW-1:0] vpos
);

  localparam logic [HW-1:0] H_LAST_T = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS_T  = HW'(H_VIS);
  localparam logic [HW-1:0] HS_BEG_T = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END_T = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [HW-1:0] ACC_T    = HW'(H_TOTAL - ACC_LEAD);
  localparam logic [VW-1:0] V_LAST_T = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_VIS_T  = VW'(V_VIS);
  localparam logic [VW-1:0] V_PRE_T  = VW'(V_VIS - 1);
  localparam logic [VW-1:0] VS_BEG_T = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END_T = VW'(V_VIS + V_FP + V_SYNC);

  p_hstep_r1: assert property (@(posedge clk) disable iff (rst)
    (hpos != H_LAST_T) |=> (hpos == $past(hpos) + 1'b1));

  p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
    (hpos == H_LAST_T) |=> (hpos == '0));

  p_vhold_r1: assert property (@(posedge clk) disable iff (rst)
    (hpos != H_LAST_T) |=> $stable(vpos));

  p_vstep_r1: assert property (@(posedge clk) disable iff (rst)
    (hpos == H_LAST_T && vpos != V_LAST_T) |=> (vpos == $past(vpos) + 1'b1));

  p_vwrap_r1: assert property (@(posedge clk) disable iff (rst)
    (hpos == H_LAST_T && vpos == V_LAST_T) |=> (vpos == '0));

  p_hsync_r2: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> (hpos >= HS_BEG_T && hpos < HS_END_T));

  p_hsync_on_r2: assert property (@(posedge clk) disable iff (rst)
    (hpos >= HS_BEG_T && hpos < HS_END_T) |-> !hsync_n);

  p_vsync_r3: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> (vpos >= VS_BEG_T && vpos < VS_END_T));

  p_vsync_on_r3: assert property (@(posedge clk) disable iff (rst)
    (vpos >= VS_BEG_T && vpos < VS_END_T) |-> !vsync_n);

  p_blank_r4: assert property (@(posedge clk) disable iff (rst)
    blank |-> (hpos >= H_VIS_T || vpos >= V_VIS_T));

  p_blank_on_r4: assert property (@(posedge clk) disable iff (rst)
    (hpos >= H_VIS_T || vpos >= V_VIS_T) |-> blank);

  p_acc_in_blank_r5: assert property (@(posedge clk) disable iff (rst)
    acc_win |-> blank);

  p_acc_open_r5: assert property (@(posedge clk) disable iff (rst)
    (blank && hpos < ACC_T) |-> acc_win);

  p_acc_lead_r5: assert property (@(posedge clk) disable iff (rst)
    (hpos >= ACC_T && (vpos < V_PRE_T || vpos == V_LAST_T)) |-> !acc_win);

  p_frame_r6: assert property (@(posedge clk) disable iff (rst)
    frame_blank |-> (vpos >= V_VIS_T && blank));

  p_frame_on_r6: assert property (@(posedge clk) disable iff (rst)
    (vpos >= V_VIS_T) |-> frame_blank);

  p_pix_r7: assert property (@(posedge clk) disable iff (rst)
    pix_en |-> (!blank && !hpos[0]));

  p_pix_on_r7: assert property (@(posedge clk) disable iff (rst)
    (!blank && !hpos[0]) |-> pix_en);

  p_reset_origin_r9: assert property (@(posedge clk)
    rst |=> (hpos == '0 && vpos == '0 && hsync_n && vsync_n && !blank
             && !acc_win && !frame_blank && pix_en));

endmodule

bind vga_raster_timer vga_raster_timer_chk #(
  .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
  .ACC_LEAD(ACC_LEAD)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hsync_n     (hsync_n),
  .vsync_n     (vsync_n),
  .blank       (blank),
  .acc_win     (acc_win),
  .frame_blank (frame_blank),
  .pix_en      (pix_en),
  .hpos        (hpos),
  .vpos        (vpos)
);

// File: tb/vga_raster_timer_test.sv
module vga_raster_timer_test;

  localparam int HV = 16, HF = 2, HS = 3, HB = 3;
  localparam int VV = 6, VF = 1, VS = 2, VB = 2;
  localparam int LEAD = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);

  typedef struct {
    int h;
    int v;
    bit in_rst;
    bit hs, vs, bl, ac, fb, pe;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_n, vsync_n, blank, acc_win, frame_blank, pix_en;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int mh = 0, mv = 0;
  int pix_cnt = 0;
  exp_t sb[$];

  vga_raster_timer #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .ACC_LEAD(LEAD)
  ) uut (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank(blank), .acc_win(acc_win), .frame_blank(frame_blank),
    .pix_en(pix_en), .hpos(hpos), .vpos(vpos)
  );

  always #4 clk = ~clk;

  function automatic exp_t model(int h, int v, bit r);
    exp_t e;
    bit off, nxt_shown;
    e.h = h; e.v = v; e.in_rst = r;
    off       = (h >= HV) || (v >= VV);
    nxt_shown = (v < VV - 1) || (v == VT - 1);
    e.hs = !(h >= HV + HF && h < HV + HF + HS);
    e.vs = !(v >= VV + VF && v < VV + VF + VS);
    e.bl = off;
    e.ac = off && !(h >= HT - LEAD && nxt_shown);
    e.fb = (v >= VV);
    e.pe = !off && (h % 2 == 0);
    return e;
  endfunction

  task automatic check(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: applies reset or free-run for one clock and queues the expectation.
  task automatic step(bit r);
    @(negedge clk);
    rst = r;
    @(posedge clk);
    if (r) begin
      mh = 0; mv = 0;
    end else if (mh == HT - 1) begin
      mh = 0;
      mv = (mv == VT - 1) ? 0 : mv + 1;
    end else begin
      mh = mh + 1;
    end
    sb.push_back(model(mh, mv, r));
  endtask

  // Monitor: compares the queued expectation with the outputs, mid-cycle.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        e = sb.pop_front();
        check(e.in_rst ? "R9" : "R1/R8", "hpos", int'(hpos), e.h);
        check(e.in_rst ? "R9" : "R1/R8", "vpos", int'(vpos), e.v);
        check(e.in_rst ? "R9" : "R2", "hsync_n", int'(hsync_n), int'(e.hs));
        check(e.in_rst ? "R9" : "R3", "vsync_n", int'(vsync_n), int'(e.vs));
        check(e.in_rst ? "R9" : "R4", "blank", int'(blank), int'(e.bl));
        check(e.in_rst ? "R9" : "R5", "acc_win", int'(acc_win), int'(e.ac));
        check(e.in_rst ? "R9" : "R6", "frame_blank", int'(frame_blank), int'(e.fb));
        check(e.in_rst ? "R9" : "R7", "pix_en", int'(pix_en), int'(e.pe));
        if (e.h == 0) pix_cnt = 0;
        if (pix_en) pix_cnt++;
        if (!e.in_rst && e.h == HT - 1 && e.v < VV)
          check("R7", "pix_en per visible line", pix_cnt, HV / 2);
      end
    end
  end

  initial begin
    repeat (3) step(1'b1);
    repeat (3 * HT * VT + 20) step(1'b0);
    repeat (2) step(1'b1);          // mid-line reset, R9
    repeat (HT * VT + 30) step(1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule